// File: doc/BRIEF.md
# Idle-Timeout Power Mode Controller

This block steps a PC-style system through four power modes as it sits idle. Mode ON is normal running. When the idle timer for the present mode runs out, the block moves one step deeper: first to DOZE, then to STANDBY, then to SUSPEND. Activity from any enabled source brings it straight back to ON. Activity from a source that is not enabled has no effect. The sources are eight device strobes, a programmable I/O address window and a maskable set of interrupt lines.

The controller drives four system outputs from its mode: a CPU clock-rate select, a secondary-cache power-down line, a power-supply shutdown line and a front-panel LED. The LED shows the mode as a blink pattern. An external push button acts as a toggle. A press in ON forces SUSPEND, and the next press returns to ON.

A divider counts system clocks to make a one-second tick, and all timeouts are counted in these seconds. Software sets up the block through a small register write port of eight words.

Top module: `pmode_ctrl`

## Requirements
- R1: After reset the block is in ON, with powerMode=0, cpuClkSel=0, cacheOff=0 and psuOff=0, and ledOut follows turboIn. The register reset values are:
  - control=0;
  - doze timeout=15;
  - standby timeout=0 and suspend timeout=0;
  - source enables=0 and IRQ enables=0;
  - window low=100h and window high=3FFh.
- R2: The register map is as follows. Writes take effect when cfgWe is high at a clock edge.
  - Address 0: bit0 is the master enable and bit1 marks a stop-clock capable CPU.
  - Addresses 1, 2 and 3 hold the DOZE, STANDBY and SUSPEND timeouts, in seconds.
  - Address 4: bits 0 to 7 enable devAct[0..7] and bit8 enables the I/O window.
  - Address 5 holds the IRQ enables.
  - Addresses 6 and 7 hold the window low and high limits, as 10 bits each.
- R3: In ON with no activity, the block enters DOZE once the doze timeout has elapsed. The timeout in use is the register value clamped to the range 15 to 30720 seconds, so a value of 5 acts as 15. Counting starts at the last timer restart.
- R4: In DOZE, the STANDBY timeout applies, and in STANDBY the SUSPEND timeout applies. A value of 0 disables that timer and holds the present mode. Any other value is clamped to the range 120 to 30720 seconds. With no activity, modes advance only in the order ON, DOZE, STANDBY, SUSPEND.
- R5: An enabled activity in ON restarts the doze timer, so the full doze timeout is counted again from that cycle.
- R6: An enabled activity in DOZE, STANDBY or SUSPEND sets powerMode to 0 at the next clock edge.
- R7: A pulse from a disabled source has no effect. Only IRQ lines 1, 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 can be enabled, so lines 0, 2, 8 and 13 never count as activity.
- R8: An I/O access counts as activity only when it lies inside the window. That is, ioStrobe is high, ioAddr is at or above the larger of window low and 100h, and ioAddr is at or below window high and 3FFh.
- R9: The clock select is set by the mode:
  - ON gives cpuClkSel=0 (full rate);
  - DOZE gives 1 (half rate);
  - STANDBY gives 2 (reduced rate);
  - SUSPEND gives 3 (stopped) when the stop-clock bit is set, and 2 otherwise.
  
  cacheOff is 1 only in SUSPEND.
- R10: The LED depends on the mode:
  - in ON, ledOut equals turboIn;
  - in DOZE, it toggles every half second, for a period of 1 s;
  - in STANDBY, it toggles every second, for a period of 2 s;
  - in SUSPEND, it is 0.
- R11: psuOff is 1 in every mode other than ON.
- R12: The button input is synchronised and debounced, and only its rising edge acts. A press in ON moves the block to SUSPEND. A press in any other mode moves it to ON. A release has no effect.
- R13: While the master enable is 0, the block returns to ON and holds there, its timers stay cleared, and button presses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgData | input | 16 | Register write data |
| devAct | input | 8 | Single-cycle device activity pulses |
| ioStrobe | input | 1 | I/O access pulse |
| ioAddr | input | 16 | I/O address of the access |
| irqPulse | input | 16 | Single-cycle interrupt activity pulses |
| turboIn | input | 1 | Turbo indicator, shown on the LED in ON |
| buttonIn | input | 1 | Raw suspend/resume button |
| powerMode | output | 2 | 0 ON, 1 DOZE, 2 STANDBY, 3 SUSPEND |
| cpuClkSel | output | 2 | 0 full, 1 half, 2 reduced, 3 stopped |
| cacheOff | output | 1 | Secondary cache power-down |
| psuOff | output | 1 | Power-supply shutdown |
| ledOut | output | 1 | Mode indicator LED |

## Verification
A wake is due at the clock edge that samples the activity pulse, so the bench checks it half a cycle later.

A timeout-driven step is due one edge after the counted seconds reach the limit, measured from the edge that restarted the timer. The bench therefore checks a few cycles before that edge and a few cycles after it, which keeps each check clear of the exact edge.

The button path has a synchroniser and a debounce filter, so its mode change lands about seven cycles after the press. The bench samples twelve cycles later.

The LED blink periods are measured by counting toggles over a whole number of seconds inside one mode, which does not depend on the phase at which the window starts.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [1:0] {
    PM_ON   = 2'd0,
    PM_DOZE = 2'd1,
    PM_STBY = 2'd2,
    PM_SUSP = 2'd3
  } pmode_t;

  localparam int NUM_DEV = 8;
  localparam int NUM_IRQ = 16;
  localparam int SEC_W = 16;
  localparam logic [SEC_W-1:0] MAX_SEC = 16'd30720;
  localparam logic [SEC_W-1:0] DOZE_MIN = 16'd15;
  localparam logic [SEC_W-1:0] DEEP_MIN = 16'd120;
  localparam logic [9:0] IO_FLOOR = 10'h100;
  localparam logic [NUM_IRQ-1:0] IRQ_ALLOWED = 16'hDEFA;

  // status from datapath to control
  typedef struct packed {
    logic       activity;
    logic       timeoutHit;
    logic       btnRise;
    logic       enabled;
    logic       stopCap;
    logic [1:0] blink;
  } dp_stat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   restart;
    pmode_t mode;
  } ctl_strobe_t;
endpackage

// File: rtl/pmode_datapath.sv
module pmode_datapath
  import pmode_pkg::*;
#(
  parameter int TICK_DIV = 33000000,
  parameter int DEBOUNCE = 330000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [15:0]          cfgData,
  input  logic [NUM_DEV-1:0]   devAct,
  input  logic                 ioStrobe,
  input  logic [15:0]          ioAddr,
  input  logic [NUM_IRQ-1:0]   irqPulse,
  input  logic                 buttonIn,
  input  ctl_strobe_t          ctl,
  output dp_stat_t             stat
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int HALF  = TICK_DIV / 2;
  localparam int DB_W  = (DEBOUNCE > 2) ? $clog2(DEBOUNCE) : 1;

  // configuration registers
  logic [1:0]         ctrlReg;
  logic [SEC_W-1:0]   dozeReg, stbyReg, suspReg;
  logic [NUM_DEV-1:0] devEn;
  logic               ioEn;
  logic [NUM_IRQ-1:0] irqEn;
  logic [9:0]         ioLo, ioHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      dozeReg <= DOZE_MIN;
      stbyReg <= '0;
      suspReg <= '0;
      devEn   <= '0;
      ioEn    <= 1'b0;
      irqEn   <= '0;
      ioLo    <= IO_FLOOR;
      ioHi    <= 10'h3FF;
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0: ctrlReg <= cfgData[1:0];
        3'd1: dozeReg <= cfgData;
        3'd2: stbyReg <= cfgData;
        3'd3: suspReg <= cfgData;
        3'd4: begin
          devEn <= cfgData[NUM_DEV-1:0];
          ioEn  <= cfgData[NUM_DEV];
        end
        3'd5: irqEn <= cfgData & IRQ_ALLOWED;
        3'd6: ioLo  <= cfgData[9:0];
        default: ioHi <= cfgData[9:0];
      endcase
    end
  end

  function automatic logic [SEC_W-1:0] clampLim(input logic [SEC_W-1:0] v,
                                                input logic [SEC_W-1:0] lo);
    if (v < lo) return lo;
    else if (v > MAX_SEC) return MAX_SEC;
    else return v;
  endfunction

  // activity detection
  logic [9:0] loEff;
  logic       ioMatch;
  assign loEff   = (ioLo < IO_FLOOR) ? IO_FLOOR : ioLo;
  assign ioMatch = ioStrobe && ioEn && (ioAddr[15:10] == 6'd0) &&
                   (ioAddr[9:0] >= loEff) && (ioAddr[9:0] <= ioHi);

  assign stat.activity = (|(devAct & devEn)) | ioMatch | (|(irqPulse & irqEn));

  // second prescaler, half-second blink and shared idle-second counter
  logic [PRE_W-1:0] pre;
  logic [SEC_W-1:0] secCnt;
  logic [1:0]       blink;
  logic             tick, halfTick;

  assign tick     = (pre == PRE_W'(TICK_DIV - 1));
  assign halfTick = tick || (pre == PRE_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || ctl.restart) begin
      pre    <= '0;
      secCnt <= '0;
      blink  <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && secCnt != '1) secCnt <= secCnt + 1'b1;
      if (halfTick) blink <= blink + 2'd1;
    end
  end

  logic [SEC_W-1:0] limit;
  logic             limitOn;
  always_comb begin
    limit   = '0;
    limitOn = 1'b0;
    case (ctl.mode)
      PM_ON: begin
        limit   = clampLim(dozeReg, DOZE_MIN);
        limitOn = 1'b1;
      end
      PM_DOZE: begin
        limit   = clampLim(stbyReg, DEEP_MIN);
        limitOn = (stbyReg != '0);
      end
      PM_STBY: begin
        limit   = clampLim(suspReg, DEEP_MIN);
        limitOn = (suspReg != '0);
      end
      default: begin
        limit   = '0;
        limitOn = 1'b0;
      end
    endcase
  end

  assign stat.timeoutHit = limitOn && (secCnt >= limit);
  assign stat.blink      = blink;
  assign stat.enabled    = ctrlReg[0];
  assign stat.stopCap    = ctrlReg[1];

  // button synchroniser and debounce
  logic [1:0]      btnSync;
  logic            btnStable, btnPrev;
  logic [DB_W-1:0] dbCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      btnSync   <= '0;
      btnStable <= 1'b0;
      btnPrev   <= 1'b0;
      dbCnt     <= '0;
    end else begin
      btnSync <= {btnSync[0], buttonIn};
      btnPrev <= btnStable;
      if (btnSync[1] == btnStable) begin
        dbCnt <= '0;
      end else if (dbCnt == DB_W'(DEBOUNCE - 1)) begin
        btnStable <= btnSync[1];
        dbCnt     <= '0;
      end else begin
        dbCnt <= dbCnt + 1'b1;
      end
    end
  end

  assign stat.btnRise = btnStable & ~btnPrev;
endmodule

// File: rtl/pmode_control.sv
module pmode_control
  import pmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dp_stat_t    stat,
  input  logic        turboIn,
  output ctl_strobe_t ctl,
  output logic [1:0]  powerMode,
  output logic [1:0]  cpuClkSel,
  output logic        cacheOff,
  output logic        psuOff,
  output logic        ledOut
);
  pmode_t mode, nextMode;

  always_comb begin
    nextMode = mode;
    if (!stat.enabled)
      nextMode = PM_ON;
    else if (stat.btnRise)
      nextMode = (mode == PM_ON) ? PM_SUSP : PM_ON;
    else if (stat.activity)
      nextMode = PM_ON;
    else if (stat.timeoutHit && mode != PM_SUSP)
      nextMode = pmode_t'(mode + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= PM_ON;
    else     mode <= nextMode;
  end

  assign ctl.mode    = mode;
  assign ctl.restart = (nextMode != mode) | stat.activity | ~stat.enabled;

  always_comb begin
    case (mode)
      PM_ON:   begin cpuClkSel = 2'd0; ledOut = turboIn;       end
      PM_DOZE: begin cpuClkSel = 2'd1; ledOut = stat.blink[0]; end
      PM_STBY: begin cpuClkSel = 2'd2; ledOut = stat.blink[1]; end
      default: begin cpuClkSel = stat.stopCap ? 2'd3 : 2'd2; ledOut = 1'b0; end
    endcase
  end

  assign powerMode = mode;
  assign cacheOff  = (mode == PM_SUSP);
  assign psuOff    = (mode != PM_ON);
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int TICK_DIV = 33000000,
  parameter int DEBOUNCE = 330000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [15:0] cfgData,
  input  logic [7:0]  devAct,
  input  logic        ioStrobe,
  input  logic [15:0] ioAddr,
  input  logic [15:0] irqPulse,
  input  logic        turboIn,
  input  logic        buttonIn,
  output logic [1:0]  powerMode,
  output logic [1:0]  cpuClkSel,
  output logic        cacheOff,
  output logic        psuOff,
  output logic        ledOut
);
  dp_stat_t    stat;
  ctl_strobe_t ctl;

  pmode_datapath #(.TICK_DIV(TICK_DIV), .DEBOUNCE(DEBOUNCE)) u_dp (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .devAct(devAct), .ioStrobe(ioStrobe), .ioAddr(ioAddr), .irqPulse(irqPulse),
    .buttonIn(buttonIn), .ctl(ctl), .stat(stat)
  );

  pmode_control u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .turboIn(turboIn), .ctl(ctl),
    .powerMode(powerMode), .cpuClkSel(cpuClkSel), .cacheOff(cacheOff),
    .psuOff(psuOff), .ledOut(ledOut)
  );
endmodule

// File: rtl/pmode_chk.sv
module pmode_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] powerMode,
  input logic       activity,
  input logic       btnRise,
  input logic       enabled,
  input logic       ledOut
);
  // R6
  wake_on_activity_chk: assert property (@(posedge clk) disable iff (rst)
    (powerMode != 2'd0 && activity) |=> (powerMode == 2'd0));

  // R5
  stay_on_activity_chk: assert property (@(posedge clk) disable iff (rst)
    (powerMode == 2'd0 && activity && !btnRise) |=> (powerMode == 2'd0));

  // R4
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    (powerMode != $past(powerMode) && !$past(btnRise)) |->
      (powerMode == 2'd0 || powerMode == $past(powerMode) + 2'd1));

  // R13
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (powerMode == 2'd0));

  // R10
  suspend_led_chk: assert property (@(posedge clk) disable iff (rst)
    (powerMode == 2'd3) |-> !ledOut);
endmodule

bind pmode_ctrl pmode_chk u_chk (
  .clk(clk), .rst(rst), .powerMode(powerMode), .activity(stat.activity),
  .btnRise(stat.btnRise), .enabled(stat.enabled), .ledOut(ledOut)
);

// File: tb/pmode_ctrl_tb.sv
module pmode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 8;
  localparam int DBC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [7:0]  devAct = '0;
  logic        ioStrobe = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [15:0] irqPulse = '0;
  logic        turboIn = 1'b0;
  logic        buttonIn = 1'b0;
  logic [1:0]  powerMode, cpuClkSel;
  logic        cacheOff, psuOff, ledOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmode_ctrl #(.TICK_DIV(TDIV), .DEBOUNCE(DBC)) u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .devAct(devAct), .ioStrobe(ioStrobe), .ioAddr(ioAddr), .irqPulse(irqPulse),
    .turboIn(turboIn), .buttonIn(buttonIn), .powerMode(powerMode),
    .cpuClkSel(cpuClkSel), .cacheOff(cacheOff), .psuOff(psuOff), .ledOut(ledOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [15:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseDev(input int idx);
    devAct[idx] = 1'b1;
    @(negedge clk);
    devAct = '0;
  endtask

  task automatic pulseIrq(input int idx);
    irqPulse[idx] = 1'b1;
    @(negedge clk);
    irqPulse = '0;
  endtask

  task automatic ioAccess(input logic [15:0] a);
    ioStrobe = 1'b1; ioAddr = a;
    @(negedge clk);
    ioStrobe = 1'b0;
  endtask

  task automatic countToggles(input int cycles, output int n);
    logic last;
    n = 0;
    last = ledOut;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ledOut != last) n++;
      last = ledOut;
    end
  endtask

  // R1
  task automatic t_reset();
    check("R1 mode", powerMode, 0);
    check("R1 clksel", cpuClkSel, 0);
    check("R1 cacheOff", cacheOff, 0);
    check("R1 psuOff", psuOff, 0);
    turboIn = 1'b1;
    #1;
    check("R1 led follows turbo", ledOut, 1);
    turboIn = 1'b0;
    #1;
    check("R1 led follows turbo low", ledOut, 0);
  endtask

  // R2 R3 R9 R11: doze value 5 acts as 15 s = 120 cycles
  task automatic t_dozeEntry();
    cfgWrite(3'd4, 16'h01F7);
    cfgWrite(3'd5, 16'hFFFF);
    cfgWrite(3'd6, 16'h0000);
    cfgWrite(3'd7, 16'h02FF);
    cfgWrite(3'd1, 16'd5);
    cfgWrite(3'd0, 16'h0001);
    waitCyc(118);
    check("R3 still ON before clamped doze timeout", powerMode, 0);
    waitCyc(5);
    check("R3 DOZE after clamped timeout", powerMode, 1);
    check("R9 DOZE clksel half", cpuClkSel, 1);
    check("R9 DOZE cache on", cacheOff, 0);
    check("R11 psuOff in DOZE", psuOff, 1);
  endtask

  // R10 doze blink
  task automatic t_ledDoze();
    int n;
    countToggles(4*TDIV, n);
    check("R10 DOZE toggles in 4 s", n, 8);
  endtask

  // R4 disabled standby timer holds
  task automatic t_hold();
    waitCyc(300);
    check("R4 disabled timer holds DOZE", powerMode, 1);
  endtask

  // R7 R8 ignored sources, then in-window wake
  task automatic t_ignored();
    pulseDev(3);
    check("R7 disabled device ignored", powerMode, 1);
    pulseIrq(2);
    check("R7 unmaskable irq2 ignored", powerMode, 1);
    pulseIrq(13);
    check("R7 unmaskable irq13 ignored", powerMode, 1);
    ioAccess(16'h00F0);
    check("R8 io below 100h ignored", powerMode, 1);
    ioAccess(16'h0300);
    check("R8 io above window ignored", powerMode, 1);
    ioAccess(16'h1100);
    check("R8 io above 3FFh ignored", powerMode, 1);
    ioAccess(16'h01F0);
    check("R8 R6 io in window wakes", powerMode, 0);
  endtask

  // R5 activity in ON restarts the doze timer
  task automatic t_restart();
    waitCyc(100);
    pulseDev(0);
    waitCyc(118);
    check("R5 restart keeps ON", powerMode, 0);
    waitCyc(5);
    check("R5 DOZE after restarted timeout", powerMode, 1);
  endtask

  // R4 R9 R10 R6 cascade: standby 130 s, suspend 50 s acts as 120 s
  task automatic t_cascade();
    int n;
    cfgWrite(3'd2, 16'd130);
    cfgWrite(3'd3, 16'd50);
    pulseDev(1);
    check("R6 wake from DOZE", powerMode, 0);
    waitCyc(118);
    check("R3 ON before doze", powerMode, 0);
    waitCyc(5);
    check("R3 DOZE", powerMode, 1);
    waitCyc(1035);
    check("R4 DOZE before standby timeout", powerMode, 1);
    waitCyc(6);
    check("R4 STANDBY after timeout", powerMode, 2);
    check("R9 STANDBY clksel", cpuClkSel, 2);
    countToggles(4*TDIV, n);
    check("R10 STANDBY toggles in 4 s", n, 4);
    waitCyc(924);
    check("R4 STANDBY before clamped suspend timeout", powerMode, 2);
    waitCyc(6);
    check("R4 SUSPEND after clamped timeout", powerMode, 3);
    check("R9 SUSPEND no stopcap clksel", cpuClkSel, 2);
    check("R9 SUSPEND cacheOff", cacheOff, 1);
    check("R11 psuOff in SUSPEND", psuOff, 1);
    turboIn = 1'b1;
    #1;
    check("R10 SUSPEND led off", ledOut, 0);
    turboIn = 1'b0;
    cfgWrite(3'd0, 16'h0003);
    check("R9 SUSPEND stopcap clksel", cpuClkSel, 3);
    waitCyc(200);
    check("R4 SUSPEND is final", powerMode, 3);
    pulseIrq(5);
    check("R6 irq5 wakes from SUSPEND", powerMode, 0);
    check("R11 psuOff clear in ON", psuOff, 0);
  endtask

  task automatic press();
    buttonIn = 1'b1;
    waitCyc(12);
  endtask

  task automatic release_btn();
    buttonIn = 1'b0;
    waitCyc(12);
  endtask

  // R12 button toggle
  task automatic t_button();
    press();
    check("R12 press in ON forces SUSPEND", powerMode, 3);
    release_btn();
    check("R12 release has no effect", powerMode, 3);
    press();
    check("R12 second press returns ON", powerMode, 0);
    release_btn();
    press();
    check("R12 third press SUSPEND", powerMode, 3);
    release_btn();
  endtask

  // R13 master enable low
  task automatic t_master();
    cfgWrite(3'd0, 16'h0000);
    waitCyc(1);
    check("R13 disable returns ON", powerMode, 0);
    waitCyc(300);
    check("R13 no timeout while disabled", powerMode, 0);
    press();
    check("R13 button ignored while disabled", powerMode, 0);
    release_btn();
    pulseDev(0);
    check("R13 psuOff clear while disabled", psuOff, 0);
  endtask

  initial begin
    waitCyc(3);
    rst = 1'b0;
    waitCyc(1);
    t_reset();
    t_dozeEntry();
    t_ledDoze();
    t_hold();
    t_ignored();
    t_restart();
    t_cascade();
    t_button();
    t_master();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule